// File: doc/BRIEF.md
# Pseudo-Associative Cache Controller

This controller sits between a processor-side request port and a slower lower-level memory. It keeps one word per set in a direct-mapped store, which it treats as two halves. A request is first looked up in its own set (the primary set). If that lookup misses, the controller makes a second probe in a partner set (the alternate set), whose index is the primary index with its top bit flipped. A match there is a slow hit. After a slow hit the two blocks trade places, so that the next access to the same address hits on the fast path.

When both probes miss on a read, the word is fetched over a fixed-latency memory port. The fetched word goes into the primary set, and the block that was there moves to the alternate set, where it replaces whatever that set held. Writes go straight through to memory and never allocate a block. Each access ends with a one-cycle response strobe together with a two-bit code that says whether it was a fast hit, a slow hit or a miss. Only one access is in flight at a time.

Top module: `psa_cache_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1 and `resp_valid`, `mem_rd` and `mem_wr` are 0. Every set is empty, so the first read of any address is a miss.
- R2: A request accepted in the cycle where `req_valid` and `req_ready` are both high, and that matches its primary set, gives `resp_valid` in the next cycle with `resp_kind` = 2'b01. For a read, `resp_rdata` carries the stored word.
- R3: After a primary miss, the set at the primary index with its MSB inverted is probed. A match there gives `resp_kind` = 2'b10 two cycles after acceptance.
- R4: A slow hit exchanges the primary and alternate blocks. The same address then hits fast, and the block that was displaced hits slow.
- R5: A read that misses in both sets pulses `mem_rd` for one cycle, two cycles after acceptance, with `mem_addr` set to the request address. `mem_rdata` is sampled exactly FILL_LAT cycles after that pulse, and the response follows one cycle later with `resp_kind` = 2'b11 and the fetched word.
- R6: On a fill, the fetched word takes the primary set and the previous primary block moves to the alternate set. The alternate set's previous block is lost and misses on its next read.
- R7: Every write sends one `mem_wr` pulse, in the same cycle as its response, carrying the address and data. A write that hits (fast or slow) updates the cached word. A write that misses responds with 2'b11 two cycles after acceptance and leaves the cache unchanged, so a later read of that address misses.
- R8: `req_ready` is low from acceptance until the access, including any swap or fill, has completed. Requests raised while it is low are ignored and produce no response and no memory traffic.
- R9: Each stored tag includes the index MSB. Two addresses with equal upper bits whose indexes differ only in the MSB are therefore distinct blocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| resp_valid | output | 1 | One-cycle completion strobe |
| resp_kind | output | 2 | 01 fast hit, 10 slow hit, 11 miss |
| resp_rdata | output | DATA_W | Read data (write data echoed for writes) |
| mem_rd | output | 1 | Fill read pulse |
| mem_wr | output | 1 | Write-through pulse |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Fill data, valid FILL_LAT cycles after `mem_rd` |

## Verification
The bench steers addresses into conflicting sets and checks the swap. A design that skipped the exchange would answer a repeat access with 2'b10 instead of 2'b01. It then fills a set whose partner is occupied and reads the evicted block again. A design that moved the wrong block, or kept both, would report a hit there instead of a miss. Two addresses whose indexes differ only in the MSB are used to catch a tag that drops that bit: such a design gives a false hit with the wrong data. Fill data is driven for a single cycle only, so a design that samples one cycle early or late returns a garbage word. A write raised during a fill must leave the memory image unchanged.

// File: rtl/psa_pkg.sv
// Shared types for the pseudo-associative cache controller.
package psa_pkg;
    typedef enum logic [1:0] {
        KIND_NONE   = 2'b00,
        KIND_FAST   = 2'b01,
        KIND_PSEUDO = 2'b10,
        KIND_MISS   = 2'b11
    } psa_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ALT,
        ST_FILL
    } psa_state_e;
endpackage

// File: rtl/psa_set_store.sv
// Per-set storage of valid bit, key and data word.
// Two combinational read ports and two write ports. Port 1 wins if both
// target one set, which the controller never does.
// Assumes the controller writes distinct indexes when it uses both ports.
module psa_set_store #(
    parameter int IDX_W  = 4,
    parameter int KEY_W  = 9,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rda_idx,
    output logic              rda_valid,
    output logic [KEY_W-1:0]  rda_key,
    output logic [DATA_W-1:0] rda_data,
    input  logic [IDX_W-1:0]  rdb_idx,
    output logic              rdb_valid,
    output logic [KEY_W-1:0]  rdb_key,
    output logic [DATA_W-1:0] rdb_data,
    input  logic              wr0_en,
    input  logic [IDX_W-1:0]  wr0_idx,
    input  logic              wr0_valid,
    input  logic [KEY_W-1:0]  wr0_key,
    input  logic [DATA_W-1:0] wr0_data,
    input  logic              wr1_en,
    input  logic [IDX_W-1:0]  wr1_idx,
    input  logic              wr1_valid,
    input  logic [KEY_W-1:0]  wr1_key,
    input  logic [DATA_W-1:0] wr1_data
);
    localparam int SETS = 1 << IDX_W;

    logic              valid_q [SETS];
    logic [KEY_W-1:0]  key_q   [SETS];
    logic [DATA_W-1:0] data_q  [SETS];

    for (genvar s = 0; s < SETS; s++) begin : g_set
        localparam logic [IDX_W-1:0] SI = IDX_W'(s);
        // Valid bit: cleared by reset, written by either port.
        always_ff @(posedge clk) begin
            if (!rst_n)
                valid_q[s] <= 1'b0;
            else if (wr1_en && wr1_idx == SI)
                valid_q[s] <= wr1_valid;
            else if (wr0_en && wr0_idx == SI)
                valid_q[s] <= wr0_valid;
        end
        // Key and data: no reset needed, qualified by the valid bit.
        always_ff @(posedge clk) begin
            if (wr1_en && wr1_idx == SI) begin
                key_q[s]  <= wr1_key;
                data_q[s] <= wr1_data;
            end else if (wr0_en && wr0_idx == SI) begin
                key_q[s]  <= wr0_key;
                data_q[s] <= wr0_data;
            end
        end
    end

    // Read ports: plain indexed selection.
    always_comb begin
        rda_valid = valid_q[rda_idx];
        rda_key   = key_q[rda_idx];
        rda_data  = data_q[rda_idx];
        rdb_valid = valid_q[rdb_idx];
        rdb_key   = key_q[rdb_idx];
        rdb_data  = data_q[rdb_idx];
    end
endmodule

// File: rtl/psa_probe.sv
// Key comparator for one probe: hit when the entry is valid and keys match.
module psa_probe #(
    parameter int KEY_W = 9
) (
    input  logic             ent_valid,
    input  logic [KEY_W-1:0] ent_key,
    input  logic [KEY_W-1:0] want_key,
    output logic             hit
);
    // Match test.
    always_comb hit = ent_valid && (ent_key == want_key);
endmodule

// File: rtl/psa_fill_timer.sv
// Counts the fixed fill latency. Started in the cycle mem_rd is launched.
// done rises in the cycle whose closing edge should capture the fill data.
// Assumes LAT >= 1.
module psa_fill_timer #(
    parameter int LAT = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int CNT_W = $clog2(LAT + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;

    // Load on start, count down while busy, stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_W'(LAT);
        end else if (busy_q) begin
            if (cnt_q == '0)
                busy_q <= 1'b0;
            else
                cnt_q <= cnt_q - 1'b1;
        end
    end

    // Completion flag.
    always_comb done = busy_q && (cnt_q == '0);
endmodule

// File: rtl/psa_cache_ctrl.sv
// Pseudo-associative cache controller: direct-mapped store, second probe
// at the MSB-inverted index, block exchange after a slow hit, read fill
// from a fixed-latency memory, write-through without allocation.
// Assumes IDX_W >= 2, ADDR_W > IDX_W, and memory always accepts writes.
module psa_cache_ctrl #(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 32,
    parameter int IDX_W    = 4,
    parameter int FILL_LAT = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              resp_valid,
    output logic [1:0]        resp_kind,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    import psa_pkg::*;

    localparam int TAG_W = ADDR_W - IDX_W;
    localparam int KEY_W = TAG_W + 1;
    localparam logic [IDX_W-1:0] MSB_MASK = {1'b1, {(IDX_W-1){1'b0}}};

    psa_state_e        state_q;
    logic [ADDR_W-1:0] lat_addr_q;
    logic              lat_write_q;
    logic [DATA_W-1:0] lat_wdata_q;
    logic              resp_valid_q, mem_rd_q, mem_wr_q;
    psa_kind_e         kind_q;
    logic [DATA_W-1:0] rdata_q, mem_wdata_q;
    logic [ADDR_W-1:0] mem_addr_q;

    logic [ADDR_W-1:0] cur_addr;
    logic [IDX_W-1:0]  cur_idx, alt_idx;
    logic [KEY_W-1:0]  cur_key;
    logic              accept;

    logic              p_valid, a_valid, p_hit, a_hit;
    logic [KEY_W-1:0]  p_key, a_key;
    logic [DATA_W-1:0] p_data, a_data;

    logic              wr0_en, wr0_valid, wr1_en, wr1_valid;
    logic [IDX_W-1:0]  wr0_idx, wr1_idx;
    logic [KEY_W-1:0]  wr0_key, wr1_key;
    logic [DATA_W-1:0] wr0_data, wr1_data;
    logic              fill_start, fill_done;

    // Address in play: live request when idle, latched one otherwise.
    always_comb begin
        cur_addr = (state_q == ST_IDLE) ? req_addr : lat_addr_q;
        cur_idx  = cur_addr[IDX_W-1:0];
        alt_idx  = cur_idx ^ MSB_MASK;
        cur_key  = {cur_addr[ADDR_W-1:IDX_W], cur_idx[IDX_W-1]};
        accept   = req_valid && (state_q == ST_IDLE);
    end

    psa_set_store #(.IDX_W(IDX_W), .KEY_W(KEY_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .rda_idx(cur_idx), .rda_valid(p_valid), .rda_key(p_key), .rda_data(p_data),
        .rdb_idx(alt_idx), .rdb_valid(a_valid), .rdb_key(a_key), .rdb_data(a_data),
        .wr0_en(wr0_en), .wr0_idx(wr0_idx), .wr0_valid(wr0_valid),
        .wr0_key(wr0_key), .wr0_data(wr0_data),
        .wr1_en(wr1_en), .wr1_idx(wr1_idx), .wr1_valid(wr1_valid),
        .wr1_key(wr1_key), .wr1_data(wr1_data)
    );

    psa_probe #(.KEY_W(KEY_W)) u_probe_p (
        .ent_valid(p_valid), .ent_key(p_key), .want_key(cur_key), .hit(p_hit)
    );
    psa_probe #(.KEY_W(KEY_W)) u_probe_a (
        .ent_valid(a_valid), .ent_key(a_key), .want_key(cur_key), .hit(a_hit)
    );

    always_comb fill_start = (state_q == ST_ALT) && !a_hit && !lat_write_q;

    psa_fill_timer #(.LAT(FILL_LAT)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(fill_start), .done(fill_done)
    );

    // Store updates: write hit, exchange after slow hit, or fill with eviction.
    always_comb begin
        wr0_en = 1'b0; wr0_idx = cur_idx; wr0_valid = 1'b1;
        wr0_key = cur_key; wr0_data = req_wdata;
        wr1_en = 1'b0; wr1_idx = alt_idx; wr1_valid = p_valid;
        wr1_key = p_key; wr1_data = p_data;
        case (state_q)
            ST_IDLE: wr0_en = accept && p_hit && req_write;
            ST_ALT: begin
                wr0_en   = a_hit;
                wr1_en   = a_hit;
                wr0_data = lat_write_q ? lat_wdata_q : a_data;
            end
            ST_FILL: begin
                wr0_en   = fill_done;
                wr1_en   = fill_done;
                wr0_data = mem_rdata;
            end
            default: ;
        endcase
    end

    // Sequencing, response and memory-port registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            lat_addr_q   <= '0;
            lat_write_q  <= 1'b0;
            lat_wdata_q  <= '0;
            resp_valid_q <= 1'b0;
            kind_q       <= KIND_NONE;
            rdata_q      <= '0;
            mem_rd_q     <= 1'b0;
            mem_wr_q     <= 1'b0;
            mem_addr_q   <= '0;
            mem_wdata_q  <= '0;
        end else begin
            resp_valid_q <= 1'b0;
            mem_rd_q     <= 1'b0;
            mem_wr_q     <= 1'b0;
            case (state_q)
                ST_IDLE: if (accept) begin
                    lat_addr_q  <= req_addr;
                    lat_write_q <= req_write;
                    lat_wdata_q <= req_wdata;
                    if (p_hit) begin
                        resp_valid_q <= 1'b1;
                        kind_q       <= KIND_FAST;
                        rdata_q      <= req_write ? req_wdata : p_data;
                        mem_wr_q     <= req_write;
                        mem_addr_q   <= req_addr;
                        mem_wdata_q  <= req_wdata;
                    end else begin
                        state_q <= ST_ALT;
                    end
                end
                ST_ALT: begin
                    mem_addr_q  <= lat_addr_q;
                    mem_wdata_q <= lat_wdata_q;
                    if (a_hit || lat_write_q) begin
                        resp_valid_q <= 1'b1;
                        kind_q       <= a_hit ? KIND_PSEUDO : KIND_MISS;
                        rdata_q      <= lat_write_q ? lat_wdata_q : a_data;
                        mem_wr_q     <= lat_write_q;
                        state_q      <= ST_IDLE;
                    end else begin
                        mem_rd_q <= 1'b1;
                        state_q  <= ST_FILL;
                    end
                end
                ST_FILL: if (fill_done) begin
                    resp_valid_q <= 1'b1;
                    kind_q       <= KIND_MISS;
                    rdata_q      <= mem_rdata;
                    state_q      <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Port assignments.
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        resp_valid = resp_valid_q;
        resp_kind  = kind_q;
        resp_rdata = rdata_q;
        mem_rd     = mem_rd_q;
        mem_wr     = mem_wr_q;
        mem_addr   = mem_addr_q;
        mem_wdata  = mem_wdata_q;
    end
endmodule

// File: rtl/psa_cache_ctrl_chk.sv
// Checker for psa_cache_ctrl, attached by bind. Observes ports plus the
// primary probe result. Counts the fill window itself instead of using a
// deep $past.
module psa_cache_ctrl_chk #(
    parameter int FILL_LAT = 50
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       p_hit,
    input logic       resp_valid,
    input logic [1:0] resp_kind,
    input logic       mem_rd,
    input logic       mem_wr
);
    int unsigned gap_q;

    // Cycles since the last fill launch, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gap_q <= 0;
        else if (mem_rd)
            gap_q <= 1;
        else if (gap_q != 0 && gap_q < FILL_LAT + 2)
            gap_q <= gap_q + 1;
    end

    assert_fast_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && p_hit) |=> (resp_valid && resp_kind == 2'b01));

    assert_kind_coded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_kind != 2'b00));

    assert_slow_after_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_kind == 2'b10) |-> !$past(req_ready));

    assert_fill_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_kind == 2'b11 && !mem_wr) |-> (gap_q == FILL_LAT + 1));

    assert_one_mem_op_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd, mem_wr}));

    assert_wr_with_resp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> resp_valid);

    assert_busy_during_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> !req_ready);
endmodule

bind psa_cache_ctrl psa_cache_ctrl_chk #(.FILL_LAT(FILL_LAT)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .p_hit(p_hit), .resp_valid(resp_valid), .resp_kind(resp_kind),
    .mem_rd(mem_rd), .mem_wr(mem_wr)
);

// File: tb/tb_psa_cache_ctrl.sv
// Directed bench for psa_cache_ctrl with a fixed-latency memory model.
module tb_psa_cache_ctrl;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int FILL_LAT = 50;
    localparam logic [DATA_W-1:0] JUNK = 32'hDEAD_BEEF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic resp_valid, mem_rd, mem_wr;
    logic [1:0] resp_kind;
    logic [DATA_W-1:0] resp_rdata, mem_wdata;
    logic [DATA_W-1:0] mem_rdata = JUNK;
    logic [ADDR_W-1:0] mem_addr;

    logic [DATA_W-1:0] mem_model [1 << ADDR_W];
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    psa_cache_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_kind(resp_kind), .resp_rdata(resp_rdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Memory: fill data valid for one cycle, FILL_LAT cycles after mem_rd.
    initial begin
        for (int i = 0; i < (1 << ADDR_W); i++)
            mem_model[i] = 32'h1000_0000 + i * 32'h0001_0203;
        forever begin
            @(negedge clk);
            if (mem_wr) mem_model[mem_addr] = mem_wdata;
            if (mem_rd) begin
                automatic logic [ADDR_W-1:0] a = mem_addr;
                repeat (FILL_LAT) @(negedge clk);
                mem_rdata = mem_model[a];
                @(negedge clk);
                mem_rdata = JUNK;
            end
        end
    end

    task automatic check(input bit ok, input string rq, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // One access: drive, wait for response, check kind, latency, data, memory side.
    task automatic access(input bit wr, input logic [ADDR_W-1:0] a,
                          input logic [DATA_W-1:0] wd, input logic [1:0] ek,
                          input int elat, input string rq);
        int lat = 1;
        int rd_lat = 0;
        logic [DATA_W-1:0] exp_d;
        @(negedge clk);
        exp_d = wr ? wd : mem_model[a];
        check(req_ready == 1'b1, rq, "ready before request", req_ready, 1);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        while (!resp_valid && lat < FILL_LAT + 20) begin
            if (mem_rd) begin
                rd_lat = lat;
                check(mem_addr == a, rq, "fill address", mem_addr, a);
            end
            @(negedge clk);
            lat++;
        end
        check(resp_kind == ek, rq, "kind", resp_kind, ek);
        check(lat == elat, rq, "latency", lat, elat);
        if (!wr) check(resp_rdata == exp_d, rq, "read data", resp_rdata, exp_d);
        if (ek == 2'b11 && !wr)
            check(rd_lat == 2, "R5", "mem_rd cycle", rd_lat, 2);
        check(mem_wr == wr, rq, "mem_wr with response", mem_wr, wr);
        if (wr) begin
            check(mem_addr == a, "R7", "write-through address", mem_addr, a);
            check(mem_wdata == wd, "R7", "write-through data", mem_wdata, wd);
        end
    endtask

    localparam int MISS_LAT = FILL_LAT + 3;
    localparam logic [ADDR_W-1:0] A_ADR = 12'h125, B_ADR = 12'h345;
    localparam logic [ADDR_W-1:0] C_ADR = 12'h12D, D_ADR = 12'h565;

    task automatic t_reset();
        @(negedge clk);
        check(req_ready && !resp_valid && !mem_rd && !mem_wr, "R1", "reset outputs",
              {req_ready, resp_valid, mem_rd, mem_wr}, 4'b1000);
        access(1'b0, A_ADR, '0, 2'b11, MISS_LAT, "R1");
    endtask

    task automatic t_fast();
        access(1'b0, A_ADR, '0, 2'b01, 1, "R2");
    endtask

    task automatic t_swap();
        access(1'b0, B_ADR, '0, 2'b11, MISS_LAT, "R6");
        access(1'b0, A_ADR, '0, 2'b10, 2, "R3");
        access(1'b0, A_ADR, '0, 2'b01, 1, "R4");
        access(1'b0, B_ADR, '0, 2'b10, 2, "R4");
        access(1'b0, B_ADR, '0, 2'b01, 1, "R4");
    endtask

    // C shares A's upper bits, index differs only in MSB.
    task automatic t_msb_key();
        access(1'b0, C_ADR, '0, 2'b11, MISS_LAT, "R9");
        access(1'b0, A_ADR, '0, 2'b01, 1, "R6");
        access(1'b0, B_ADR, '0, 2'b11, MISS_LAT, "R6");
    endtask

    task automatic t_write();
        access(1'b1, B_ADR, 32'hB0B0_0001, 2'b01, 1, "R7");
        access(1'b0, B_ADR, '0, 2'b01, 1, "R7");
        access(1'b1, A_ADR, 32'hA0A0_0002, 2'b10, 2, "R7");
        access(1'b0, A_ADR, '0, 2'b01, 1, "R7");
        check(mem_model[A_ADR] == 32'hA0A0_0002, "R7", "memory copy",
              mem_model[A_ADR], 32'hA0A0_0002);
        access(1'b1, D_ADR, 32'hD0D0_0003, 2'b11, 2, "R7");
        access(1'b0, D_ADR, '0, 2'b11, MISS_LAT, "R7");
    endtask

    // A write raised during a fill must be dropped.
    task automatic t_busy();
        int resp_cnt = 0;
        int wr_cnt = 0;
        logic [DATA_W-1:0] orig = mem_model[12'h7A2];
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 12'h777;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (5) @(negedge clk);
        check(req_ready == 1'b0, "R8", "ready during fill", req_ready, 0);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h7A2; req_wdata = 32'h5555_AAAA;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < FILL_LAT + 10; i++) begin
            if (resp_valid) resp_cnt++;
            if (mem_wr) wr_cnt++;
            @(negedge clk);
        end
        check(resp_cnt == 1, "R8", "responses in window", resp_cnt, 1);
        check(wr_cnt == 0, "R8", "writes in window", wr_cnt, 0);
        check(mem_model[12'h7A2] == orig, "R8", "memory untouched", mem_model[12'h7A2], orig);
        access(1'b0, 12'h7A2, '0, 2'b11, MISS_LAT, "R8");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fast();
        t_swap();
        t_msb_key();
        t_write();
        t_busy();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule